// File: doc/BRIEF.md
# Next Program Counter Selector

This block decides where instruction fetch goes next in a 32-bit RISC pipeline. It takes the address of the current instruction, its 32-bit encoding, the two source register values read for it and the floating-point compare flag. From these it returns the address of the following instruction. For a call it also returns a request to write the return address into the link register.

The block is purely combinational. A small decoder classifies the instruction into a set of select strobes, and a datapath forms the sequential, relative, absolute and register-indirect candidates and picks one. Delay-slot handling, exceptions, fetch and the register file sit outside the block.

Top module: `npc_unit`

## Requirements
- R1: For any instruction that is not a control transfer, and for a conditional branch whose condition is false, `nextPc` equals `pc + 4` (modulo 2^32).
- R2: Opcode 0x04 (bits 31:26) is an equal-compare branch: it is taken when `rsVal == rtVal`.
- R3: Opcode 0x05 is a not-equal-compare branch: it is taken when `rsVal != rtVal`.
- R4: The target of a taken branch is `pc + 4` plus the 16-bit field in bits 15:0, sign-extended and multiplied by four. The sum wraps modulo 2^32, and negative offsets are allowed.
- R5: Opcode 0x11 with bits 25:21 equal to 8 is a flag branch. When bit 16 is 1 it is taken if `fpCond` is 1. When bit 16 is 0 it is taken if `fpCond` is 0.
- R6: Opcode 0x02 is an absolute jump. Its target is bits 31:28 of `pc + 4`, then bits 25:0 of the instruction, then two zero bits.
- R7: Opcode 0x03 jumps to the same target as R6. It also sets `linkWe` to 1 with `linkVal = pc + 8`. `linkIdx` is always 31.
- R8: Opcode 0x00 with bits 5:0 equal to 0x08 is a register jump: `nextPc = rsVal`.
- R9: `linkWe` is 1 only for opcode 0x03. Opcode 0x00 with any other function code gives `nextPc = pc + 4`.
- R10: Opcode 0x11 with bits 25:21 not equal to 8 is not a control transfer, whatever `fpCond` and bit 16 are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Encoding of the current instruction |
| rsVal | input | 32 | First source register value |
| rtVal | input | 32 | Second source register value |
| fpCond | input | 1 | Floating-point compare flag |
| nextPc | output | 32 | Address of the next instruction |
| linkWe | output | 1 | Write request for the link register |
| linkIdx | output | 5 | Link register index (constant 31) |
| linkVal | output | 32 | Return address to be written |

## Verification
The sweeps place `pc` near the top of a 256 MB region and near the top of the address space. A design that took the region bits from `pc` instead of `pc + 4` would then jump into the wrong region. A design that failed to wrap would also produce wrong targets there.

Branch offsets of 0x8000 and 0xFFFF test the sign extension. A design that zero-extended the offset, or forgot to scale it by four, would branch forward by the wrong distance.

The flag branch is driven with all four combinations of `fpCond` and bit 16, and the format field is swept over all 32 values. This catches an inverted sense and a decoder that ignores the format field. Every function code under opcode 0 is also tried, together with the link value, so that a link offset of 4 or a link write on a register jump is caught.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int FMT_W   = 5;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h02;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BRANCH_EQ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRANCH_NE = 6'h05;
  localparam logic [OPC_W-1:0] OPC_COPROC1 = 6'h11;

  localparam logic [FUNCT_W-1:0] FUNCT_REG_JUMP = 6'h08;
  localparam logic [FMT_W-1:0]   FMT_FLAG_BRANCH = 5'd8;

  typedef struct packed {
    logic selRegTarget;
    logic selAbsTarget;
    logic selRelTarget;
    logic linkWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
  import npc_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               regsEqual,
  input  logic               fpCond,
  output ctrlStrobes_t       strobes
);
  localparam int OPC_LSB   = INSTR_W - OPC_W;
  localparam int FMT_LSB   = OPC_LSB - FMT_W;
  localparam int SENSE_BIT = 16;

  logic [OPC_W-1:0]   opcode;
  logic [FUNCT_W-1:0] funct;
  logic [FMT_W-1:0]   fmtField;
  logic               senseBit;

  assign opcode   = instr[INSTR_W-1:OPC_LSB];
  assign funct    = instr[FUNCT_W-1:0];
  assign fmtField = instr[OPC_LSB-1:FMT_LSB];
  assign senseBit = instr[SENSE_BIT];

  logic isRegJump, isAbsJump, isCall, isBrEq, isBrNe, isFlagBr;
  logic condMet;

  always_comb begin
    isRegJump = (opcode == OPC_SPECIAL) && (funct == FUNCT_REG_JUMP);
    isAbsJump = (opcode == OPC_JUMP);
    isCall    = (opcode == OPC_CALL);
    isBrEq    = (opcode == OPC_BRANCH_EQ);
    isBrNe    = (opcode == OPC_BRANCH_NE);
    isFlagBr  = (opcode == OPC_COPROC1) && (fmtField == FMT_FLAG_BRANCH);

    condMet = 1'b0;
    if (isBrEq)   condMet = regsEqual;
    if (isBrNe)   condMet = !regsEqual;
    if (isFlagBr) condMet = (fpCond == senseBit);

    strobes.selRegTarget = isRegJump;
    strobes.selAbsTarget = isAbsJump || isCall;
    strobes.selRelTarget = condMet;
    strobes.linkWrite    = isCall;
  end
endmodule

// File: rtl/npc_datapath.sv
`timescale 1ns/1ps
module npc_datapath
  import npc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int INSTR_W   = 32,
  parameter int OFFSET_W  = 16,
  parameter int REGION_W  = 4
) (
  input  logic [ADDR_W-1:0]  pc,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  rsVal,
  input  logic [ADDR_W-1:0]  rtVal,
  input  ctrlStrobes_t       strobes,
  output logic               regsEqual,
  output logic [ADDR_W-1:0]  nextPc,
  output logic [ADDR_W-1:0]  returnAddr
);
  localparam int WORD_SHIFT = 2;
  localparam int INDEX_W    = ADDR_W - REGION_W - WORD_SHIFT;
  localparam int EXT_W      = ADDR_W - OFFSET_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0]   seqAddr;
  logic [ADDR_W-1:0]   relOffset;
  logic [ADDR_W-1:0]   relTarget;
  logic [ADDR_W-1:0]   absTarget;
  logic [OFFSET_W-1:0] offsetField;
  logic [INDEX_W-1:0]  indexField;

  assign offsetField = instr[OFFSET_W-1:0];
  assign indexField  = instr[INDEX_W-1:0];

  assign seqAddr    = pc + STEP;
  assign returnAddr = seqAddr + STEP;
  assign regsEqual  = (rsVal == rtVal);

  assign relOffset = {{EXT_W{offsetField[OFFSET_W-1]}}, offsetField, {WORD_SHIFT{1'b0}}};
  assign relTarget = seqAddr + relOffset;
  assign absTarget = {seqAddr[ADDR_W-1 -: REGION_W], indexField, {WORD_SHIFT{1'b0}}};

  always_comb begin
    nextPc = seqAddr;
    if (strobes.selRelTarget) nextPc = relTarget;
    if (strobes.selAbsTarget) nextPc = absTarget;
    if (strobes.selRegTarget) nextPc = rsVal;
  end
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG = 31
) (
  input  logic [ADDR_W-1:0]    pc,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [ADDR_W-1:0]    rsVal,
  input  logic [ADDR_W-1:0]    rtVal,
  input  logic                 fpCond,
  output logic [ADDR_W-1:0]    nextPc,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [ADDR_W-1:0]    linkVal
);
  ctrlStrobes_t strobes;
  logic         regsEqual;

  npc_decode #(.INSTR_W(INSTR_W)) u_decode (
    .instr     (instr),
    .regsEqual (regsEqual),
    .fpCond    (fpCond),
    .strobes   (strobes)
  );

  npc_datapath #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_datapath (
    .pc         (pc),
    .instr      (instr),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .strobes    (strobes),
    .regsEqual  (regsEqual),
    .nextPc     (nextPc),
    .returnAddr (linkVal)
  );

  assign linkWe  = strobes.linkWrite;
  assign linkIdx = REG_IDX_W'(LINK_REG);
endmodule

// File: rtl/npc_unit_checker.sv
`timescale 1ns/1ps
module npc_unit_checker #(
  parameter int ADDR_W    = 32,
  parameter int INSTR_W   = 32,
  parameter int REG_IDX_W = 5
) (
  input logic [ADDR_W-1:0]    pc,
  input logic [INSTR_W-1:0]   instr,
  input logic [ADDR_W-1:0]    rsVal,
  input logic [ADDR_W-1:0]    rtVal,
  input logic                 fpCond,
  input logic [ADDR_W-1:0]    nextPc,
  input logic                 linkWe,
  input logic [REG_IDX_W-1:0] linkIdx,
  input logic [ADDR_W-1:0]    linkVal
);
  logic [5:0] opc;
  logic [ADDR_W-1:0] seq;
  assign opc = instr[INSTR_W-1 -: 6];
  assign seq = pc + ADDR_W'(4);

  always_comb begin
    // R9: a link write appears for the call opcode and nothing else
    assert_link_only_call_R9: assert (linkWe == (opc == 6'h03));
    // R7: the return address skips the delay slot
    if (linkWe) assert_link_value_R7: assert (linkVal == pc + ADDR_W'(8));
    assert_link_index_R7: assert (linkIdx == REG_IDX_W'(31));
    // R6: absolute targets stay in the region of pc+4 and are word aligned
    if (opc == 6'h02 || opc == 6'h03)
      assert_jump_region_R6: assert (nextPc[ADDR_W-1 -: 4] == seq[ADDR_W-1 -: 4] && nextPc[1:0] == 2'b00);
    // R8: register jump follows the first source value
    if (opc == 6'h00 && instr[5:0] == 6'h08)
      assert_reg_jump_R8: assert (nextPc == rsVal);
    // R1: instructions outside the control set fall through
    if (!(opc inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h11}))
      assert_fall_through_R1: assert (nextPc == seq);
    // R4: relative targets keep the word offset of pc
    if (opc == 6'h04 || opc == 6'h05 || opc == 6'h11)
      assert_rel_alignment_R4: assert (nextPc[1:0] == pc[1:0]);
  end
endmodule

bind npc_unit npc_unit_checker #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .REG_IDX_W(REG_IDX_W)
) u_checker (.*);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] pc, instr, rsVal, rtVal;
  logic        fpCond;
  logic [31:0] nextPc, linkVal;
  logic        linkWe;
  logic [4:0]  linkIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  npc_unit u_npc_unit (
    .pc(pc), .instr(instr), .rsVal(rsVal), .rtVal(rtVal), .fpCond(fpCond),
    .nextPc(nextPc), .linkWe(linkWe), .linkIdx(linkIdx), .linkVal(linkVal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h (pc=%08h instr=%08h)", req, act, exp, pc, instr);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b, input logic f);
    @(negedge clk);
    pc = p; instr = i; rsVal = a; rtVal = b; fpCond = f;
    #1;
  endtask

  function automatic logic [31:0] relTgt(input logic [31:0] p, input logic [15:0] off);
    logic signed [31:0] sOff;
    sOff = $signed({{16{off[15]}}, off}) * 4;
    return p + 32'd4 + sOff;
  endfunction

  logic [31:0] pcSet [6] = '{32'h0000_0000, 32'h0040_0100, 32'h0FFF_FFFC,
                             32'h7FFF_FFF8, 32'hFFFF_FFFC, 32'h8000_0010};
  logic [15:0] offSet [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                              16'h8000, 16'h0123, 16'hFF00, 16'h0040};

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pc = 0; instr = 0; rsVal = 0; rtVal = 0; fpCond = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Initial state, a shift-nop: R1
    apply(32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
    chk("R1 nop", nextPc, 32'h4);
    chk("R9 nop link", {31'b0, linkWe}, 32'h0);

    // Equal and not-equal branches: R2 R3 R4
    foreach (pcSet[pi]) foreach (offSet[oi]) for (int eq = 0; eq < 2; eq++) begin
      logic [31:0] a, b;
      a = 32'hDEAD_0000 + 32'(oi);
      b = eq ? a : a ^ 32'h0001_0000;
      apply(pcSet[pi], {6'h04, 5'd1, 5'd2, offSet[oi]}, a, b, 1'b0);
      chk("R2 beq", nextPc, eq ? relTgt(pcSet[pi], offSet[oi]) : pcSet[pi] + 32'd4);
      apply(pcSet[pi], {6'h05, 5'd1, 5'd2, offSet[oi]}, a, b, 1'b0);
      chk("R3 bne", nextPc, !eq ? relTgt(pcSet[pi], offSet[oi]) : pcSet[pi] + 32'd4);
      chk("R4 link off", {31'b0, linkWe}, 32'h0);
    end

    // Flag branches, all flag/sense combinations: R5
    foreach (pcSet[pi]) foreach (offSet[oi]) for (int c = 0; c < 4; c++) begin
      logic sense, flag;
      sense = c[1]; flag = c[0];
      apply(pcSet[pi], {6'h11, 5'd8, 4'd0, sense, offSet[oi]}, 32'h1, 32'h2, flag);
      chk("R5 flag branch", nextPc, (sense == flag) ? relTgt(pcSet[pi], offSet[oi]) : pcSet[pi] + 32'd4);
    end

    // Other format values under the coprocessor opcode: R10
    for (int fmt = 0; fmt < 32; fmt++) begin
      if (fmt == 8) continue;
      for (int c = 0; c < 4; c++) begin
        apply(32'h0000_1000, {6'h11, 5'(fmt), 4'd0, c[1], 16'h0010}, 32'h5, 32'h5, c[0]);
        chk("R10 non-branch fmt", nextPc, 32'h0000_1004);
      end
    end

    // Absolute jump and call: R6 R7
    foreach (pcSet[pi]) for (int k = 0; k < 4; k++) begin
      logic [25:0] idx;
      logic [31:0] seq;
      idx = (k == 0) ? 26'h0 : (k == 1) ? 26'h3FF_FFFF : (k == 2) ? 26'h123_4567 : 26'h200_0001;
      seq = pcSet[pi] + 32'd4;
      apply(pcSet[pi], {6'h02, idx}, 32'hAAAA_AAAA, 32'h0, 1'b1);
      chk("R6 jump target", nextPc, {seq[31:28], idx, 2'b00});
      chk("R9 jump no link", {31'b0, linkWe}, 32'h0);
      apply(pcSet[pi], {6'h03, idx}, 32'hAAAA_AAAA, 32'h0, 1'b0);
      chk("R7 call target", nextPc, {seq[31:28], idx, 2'b00});
      chk("R7 call link we", {31'b0, linkWe}, 32'h1);
      chk("R7 call link val", linkVal, pcSet[pi] + 32'd8);
      chk("R7 call link idx", {27'b0, linkIdx}, 32'd31);
    end

    // Register jump: R8
    foreach (pcSet[pi]) for (int k = 0; k < 3; k++) begin
      logic [31:0] tgt;
      tgt = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFC : 32'h1234_5678;
      apply(pcSet[pi], {6'h00, 5'd31, 15'd0, 6'h08}, tgt, ~tgt, 1'b1);
      chk("R8 reg jump", nextPc, tgt);
      chk("R8 reg jump no link", {31'b0, linkWe}, 32'h0);
    end

    // Every other function code under opcode 0: R9
    for (int f = 0; f < 64; f++) begin
      if (f == 8) continue;
      apply(32'h0040_0000, {6'h00, 5'd3, 5'd4, 5'd5, 5'd0, 6'(f)}, 32'h9999_0000, 32'h0, 1'b0);
      chk("R9 opcode0 non-jump", nextPc, 32'h0040_0004);
      chk("R9 opcode0 link", {31'b0, linkWe}, 32'h0);
    end

    // Every opcode outside the control set: R1
    for (int o = 0; o < 64; o++) begin
      if (o inside {0, 2, 3, 4, 5, 17}) continue;
      apply(32'hFFFF_FFFC, {6'(o), 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b1);
      chk("R1 non-control", nextPc, 32'h0000_0000);
      chk("R9 non-control link", {31'b0, linkWe}, 32'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule